// File: doc/BRIEF.md
# Autovectored Interrupt Priority Glue

This block sits between seven active-low peripheral interrupt lines and a host processor that takes interrupts as a three-bit priority level. It finds the highest pending request and presents that level to the processor on three active-low level pins. The level is written there as the bitwise inverse of its number and is registered on the system clock, so the pins never glitch.

The processor acknowledges an interrupt by driving all three function-code outputs high. It places the acknowledged level on address lines A[3:1] and asserts its address strobe. The block recognises this cycle and answers with an active-low valid-peripheral-address handshake. No vector byte is returned: the processor builds the autovector itself.

For checking, the block reports the autovector number and the exception-table address that belong to the acknowledged level. A sticky flag is set when an acknowledge names a level other than the one the block was presenting. Such an acknowledge is still answered.

Top module: `irq_autovec_glue`

## Requirements
- R1: After reset `ipl_n` is 3'b111, `vpa_n` is 1, `vec_num` is 0, `vec_addr` is 0 and `ack_mismatch` is 0.
- R2: `req_n[i]` low is a request at level i+1. One clock edge after any request is low, `ipl_n` equals the bitwise inverse of the highest requesting level (level 6 appears as 3'b001).
- R3: Level 7 (`req_n[6]`) has the highest priority and level 1 (`req_n[0]`) the lowest. For several requests, only the highest is encoded.
- R4: When no request line is low, `ipl_n` is 3'b111 (level 0) one edge later.
- R5: An acknowledge is a cycle where `fc` is 3'b111 and `as_n` is low. At the clock edge that samples one, `vpa_n` goes low.
- R6: At any edge where `as_n` is high or `fc` is not 3'b111, `vpa_n` is high. This means the handshake is removed at the first edge after `as_n` is negated.
- R7: At the edge that samples the first cycle of an acknowledge, `vec_num` becomes 24 plus `addr_lvl` (vectors 25 to 31 for levels 1 to 7). At all other times it holds its value.
- R8: `vec_addr` always equals 4 times `vec_num`, so levels 1 to 7 give 0x064 to 0x07C, and level 6 gives 0x078.
- R9: If `addr_lvl` differs from the level on `ipl_n` at the start of an acknowledge, `vpa_n` is still asserted and `ack_mismatch` is set at that edge.
- R10: `ack_mismatch` stays set until reset, including through later matching acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 7 | Active-low requests, bit i is level i+1 |
| ipl_n | output | 3 | Inverted binary level to the processor |
| fc | input | 3 | Processor function code |
| addr_lvl | input | 3 | Address lines A[3:1], acknowledged level |
| as_n | input | 1 | Active-low address strobe |
| vpa_n | output | 1 | Active-low valid-peripheral-address handshake |
| vec_num | output | 8 | Autovector number of the last acknowledge |
| vec_addr | output | 10 | Exception-table address of that vector |
| ack_mismatch | output | 1 | Sticky flag: acknowledged level differed from presented level |

## Verification
A change in the request lines and the start of an acknowledge can fall on the same clock edge. At that edge the encoded level moves while the acknowledged level is compared against it. The bench provokes this by presenting level 4, then raising a level-7 request in the same cycle that an acknowledge for level 4 begins. It judges that `ack_mismatch` stays clear, because the comparison uses the level the processor saw before the edge. It also checks that `ipl_n` shows level 7 and `vpa_n` is low after that same edge.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  // Function-code value that marks an interrupt-acknowledge bus cycle
  localparam logic [2:0] FC_IACK = 3'b111;

  // Highest active-high request index plus one; 0 when none
  function automatic int unsigned top_level(input logic [31:0] act, input int unsigned n);
    int unsigned lvl;
    lvl = 0;
    for (int unsigned i = 0; i < n; i++) begin
      if (act[i]) lvl = i + 1;
    end
    return lvl;
  endfunction
endpackage

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
  parameter int LVL_W = 3,
  localparam int NUM_REQ = (1 << LVL_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_n,
  output logic [LVL_W-1:0]   ipl_n,
  output logic [LVL_W-1:0]   lvl_q
);
  import irqv_pkg::*;

  logic [31:0]      act;
  logic [LVL_W-1:0] lvl_d;

  // Active-high request vector, padded to the function width
  always_comb begin
    act = '0;
    for (int i = 0; i < NUM_REQ; i++) act[i] = ~req_n[i];
  end

  always_comb lvl_d = LVL_W'(top_level(act, NUM_REQ));

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      ipl_n <= '1;
    end else begin
      lvl_q <= lvl_d;
      ipl_n <= ~lvl_d;
    end
  end

  p_top_wins_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!req_n[NUM_REQ-1]) |-> (ipl_n == '0));
  p_pending_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!req_n[0]) |-> (ipl_n != '1));
  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    $past(&req_n) |-> (ipl_n == '1));
endmodule

// File: rtl/irqv_ack_dec.sv
module irqv_ack_dec #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       fc,
  input  logic             as_n,
  input  logic [LVL_W-1:0] addr_lvl,
  input  logic [LVL_W-1:0] cur_lvl,
  output logic             ack_start,
  output logic             vpa_n,
  output logic             mismatch
);
  import irqv_pkg::*;

  logic fc_iack;
  logic ack_on;

  always_comb begin
    fc_iack   = (fc == FC_IACK);
    ack_on    = fc_iack && !as_n;
    ack_start = ack_on && vpa_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vpa_n    <= 1'b1;
      mismatch <= 1'b0;
    end else begin
      vpa_n <= ~ack_on;
      if (ack_start && (addr_lvl != cur_lvl)) mismatch <= 1'b1;
    end
  end

  p_ack_vpa_r5: assert property (@(posedge clk) disable iff (rst)
    (!as_n && fc == 3'b111) |=> !vpa_n);
  p_no_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (as_n || fc != 3'b111) |=> vpa_n);
  p_mismatch_answered_r9: assert property (@(posedge clk) disable iff (rst)
    (!as_n && fc == 3'b111 && vpa_n && addr_lvl != cur_lvl) |=> (mismatch && !vpa_n));
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    $past(mismatch) |-> mismatch);
endmodule

// File: rtl/irqv_vec_gen.sv
module irqv_vec_gen #(
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int ADDR_W   = 10,
  parameter int VEC_BASE = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LVL_W-1:0]  lvl,
  output logic [VEC_W-1:0]  vec_num,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam int SHIFT = 2;

  logic [VEC_W-1:0] vec_d;

  always_comb vec_d = VEC_W'(VEC_BASE) + VEC_W'(lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_num  <= '0;
      vec_addr <= '0;
    end else if (load) begin
      vec_num  <= vec_d;
      vec_addr <= ADDR_W'(vec_d) << SHIFT;
    end
  end

  p_vec_load_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> (vec_num == VEC_W'(VEC_BASE) + VEC_W'($past(lvl))));
  p_vec_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(vec_num));
  p_addr_align_r8: assert property (@(posedge clk) disable iff (rst)
    vec_addr[SHIFT-1:0] == '0);
endmodule

// File: rtl/irq_autovec_glue.sv
module irq_autovec_glue #(
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int ADDR_W   = 10,
  parameter int VEC_BASE = 24,
  localparam int NUM_REQ = (1 << LVL_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_n,
  output logic [LVL_W-1:0]   ipl_n,
  input  logic [2:0]         fc,
  input  logic [LVL_W-1:0]   addr_lvl,
  input  logic               as_n,
  output logic               vpa_n,
  output logic [VEC_W-1:0]   vec_num,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic               ack_mismatch
);
  logic [LVL_W-1:0] lvl_q;
  logic             ack_start;

  irqv_prio_enc #(.LVL_W(LVL_W)) u_enc (
    .clk(clk), .rst(rst), .req_n(req_n), .ipl_n(ipl_n), .lvl_q(lvl_q)
  );

  irqv_ack_dec #(.LVL_W(LVL_W)) u_ack (
    .clk(clk), .rst(rst), .fc(fc), .as_n(as_n), .addr_lvl(addr_lvl),
    .cur_lvl(lvl_q), .ack_start(ack_start), .vpa_n(vpa_n), .mismatch(ack_mismatch)
  );

  irqv_vec_gen #(.LVL_W(LVL_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_vec (
    .clk(clk), .rst(rst), .load(ack_start), .lvl(addr_lvl),
    .vec_num(vec_num), .vec_addr(vec_addr)
  );
endmodule

// File: tb/irq_autovec_glue_tb.sv
module irq_autovec_glue_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] req_n = '1;
  logic [2:0] ipl_n;
  logic [2:0] fc = 3'b000;
  logic [2:0] addr_lvl = 3'b000;
  logic       as_n = 1'b1;
  logic       vpa_n;
  logic [7:0] vec_num;
  logic [9:0] vec_addr;
  logic       ack_mismatch;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_autovec_glue u_dut (
    .clk(clk), .rst(rst), .req_n(req_n), .ipl_n(ipl_n), .fc(fc),
    .addr_lvl(addr_lvl), .as_n(as_n), .vpa_n(vpa_n), .vec_num(vec_num),
    .vec_addr(vec_addr), .ack_mismatch(ack_mismatch)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(ipl_n == 3'b111, "R1 ipl_n", ipl_n, 7);
    chk(vpa_n == 1'b1, "R1 vpa_n", vpa_n, 1);
    chk(vec_num == 0 && vec_addr == 0, "R1 vector", vec_num, 0);
    chk(ack_mismatch == 1'b0, "R1 mismatch", ack_mismatch, 0);
  endtask

  task automatic t_priority();
    for (int l = 1; l <= 7; l++) begin
      req_n = ~(7'd1 << (l - 1));
      tick();
      chk(ipl_n == ~3'(l), "R2 single level", ipl_n, int'(~3'(l)));
    end
    req_n = ~7'b0010010;            // levels 2 and 5
    tick();
    chk(ipl_n == 3'b010, "R3 levels 2+5", ipl_n, 2);
    req_n = '0;                     // all pending
    tick();
    chk(ipl_n == 3'b000, "R3 all pending", ipl_n, 0);
    req_n = ~7'b0000101;            // levels 1 and 3
    tick();
    chk(ipl_n == 3'b100, "R3 levels 1+3", ipl_n, 4);
    req_n = '1;
    tick();
    chk(ipl_n == 3'b111, "R4 no request", ipl_n, 7);
  endtask

  task automatic do_ack(input int l, input bit exp_mis);
    fc = 3'b111; addr_lvl = 3'(l); as_n = 1'b0;
    tick();
    chk(vpa_n == 1'b0, "R5 vpa asserted", vpa_n, 0);
    chk(vec_num == 8'(24 + l), "R7 vector number", vec_num, 24 + l);
    chk(vec_addr == 10'((24 + l) * 4), "R8 table address", vec_addr, (24 + l) * 4);
    chk(ack_mismatch == exp_mis, "R9 mismatch flag", ack_mismatch, exp_mis);
    as_n = 1'b1; fc = 3'b000;
    tick();
    chk(vpa_n == 1'b1, "R6 vpa removed", vpa_n, 1);
    chk(vec_num == 8'(24 + l), "R7 vector held", vec_num, 24 + l);
  endtask

  task automatic t_ack_levels();
    for (int l = 1; l <= 7; l++) begin
      req_n = ~(7'd1 << (l - 1));
      tick();
      do_ack(l, 1'b0);
    end
    chk(vec_addr == 10'h07C, "R8 level7 0x07C", vec_addr, 'h7C);
    req_n = ~7'b0100000;
    tick();
    do_ack(6, 1'b0);
    chk(vec_addr == 10'h078, "R8 level6 0x078", vec_addr, 'h78);
  endtask

  task automatic t_gating();
    int v0;
    v0 = vec_num;
    fc = 3'b110; addr_lvl = 3'd2; as_n = 1'b0;
    tick();
    chk(vpa_n == 1'b1, "R6 fc=6 ignored", vpa_n, 1);
    chk(vec_num == v0, "R7 fc=6 no load", vec_num, v0);
    fc = 3'b111; as_n = 1'b1;
    tick();
    chk(vpa_n == 1'b1, "R6 strobe high ignored", vpa_n, 1);
    chk(vec_num == v0, "R7 strobe high no load", vec_num, v0);
    fc = 3'b000;
  endtask

  task automatic t_same_cycle();
    req_n = ~7'b0001000;            // level 4
    tick();
    req_n = ~7'b1001000;            // level 7 rises with the acknowledge
    fc = 3'b111; addr_lvl = 3'd4; as_n = 1'b0;
    tick();
    chk(ipl_n == 3'b000, "R3 level7 during ack", ipl_n, 0);
    chk(vpa_n == 1'b0, "R5 vpa same cycle", vpa_n, 0);
    chk(ack_mismatch == 1'b0, "R9 no mismatch same cycle", ack_mismatch, 0);
    chk(vec_num == 8'd28, "R7 vector same cycle", vec_num, 28);
    as_n = 1'b1; fc = 3'b000;
    tick();
    chk(vpa_n == 1'b1, "R6 vpa released", vpa_n, 1);
  endtask

  task automatic t_mismatch();
    req_n = ~7'b0000100;            // level 3
    tick();
    do_ack(5, 1'b1);
    req_n = ~7'b0000010;            // level 2, matching acknowledge
    tick();
    do_ack(2, 1'b1);
    chk(ack_mismatch == 1'b1, "R10 sticky", ack_mismatch, 1);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk(ack_mismatch == 1'b0, "R10 cleared by reset", ack_mismatch, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    t_reset();
    t_priority();
    t_ack_levels();
    t_gating();
    t_same_cycle();
    t_mismatch();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule